// File: doc/BRIEF.md
# Paged Address Translator with Identifier-Tagged TLB

This block turns a virtual address into a physical address. It reads a single-level page table that sits in external memory, and it keeps a small fully associative lookaside buffer in front of that table. A requester presents a virtual address and an address-space identifier, then holds them. The block answers with a one-cycle completion pulse. The pulse carries either a physical address or a fault flag.

The virtual address splits into a page number (upper bits) and a byte offset (low `PG_SHIFT` bits). On a buffer hit the frame number comes straight from the buffer, and no memory is touched. On a miss the page number is first compared against the table length. Only if it is in range does the block issue one read, at the table base plus the page number times the entry size. An entry fetched with its valid bit set is installed in the buffer by round-robin replacement. A clear valid bit raises a fault and installs nothing. The buffer can be emptied all at once, or only for the entries of one identifier.

Top module: `pg_xlate`

## Requirements
- R1: A request whose page number and identifier both match a buffer entry completes with `done` one cycle after it is accepted. It returns `pa` = {stored frame, unchanged offset} with `fault` low, and raises no memory request.
- R2: A request that misses with page number below `tbl_len` raises `mem_req` with `mem_addr` = `tbl_base` + page number × 4. It performs exactly one read. `done` follows one cycle after `mem_ack`. Entry format: bit 0 is valid, bits 31:12 are the frame.
- R3: A miss whose page number is greater than or equal to `tbl_len` completes one cycle after acceptance with `fault` high and `pa` zero, and performs no memory read.
- R4: A fetched entry with valid bit 0 completes with `fault` high. Nothing is installed, so repeating the same request walks the table again.
- R5: A hit requires the identifier to match as well as the page number. The same page requested under another identifier misses and walks.
- R6: A fetched entry with valid bit 1 is installed, so repeating the same request hits with no memory read. At most one entry ever matches a lookup.
- R7: Replacement is round-robin. After eight installs, the ninth install overwrites the entry installed first, and the entry installed second still hits.
- R8: A one-cycle pulse on `flush_all` invalidates every buffer entry, so later requests walk the table.
- R9: A one-cycle pulse on `flush_sel` invalidates only the entries whose identifier equals `flush_id`. Entries of other identifiers still hit.
- R10: `done` is high for exactly one cycle per request. While `mem_req` waits for `mem_ack`, it stays high and `mem_addr` stays stable.
- R11: After reset `done` and `mem_req` are low and the buffer holds no valid entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request, held until `done` |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier of the request |
| tbl_base | input | 32 | Byte address of page table entry 0 |
| tbl_len | input | 21 | Number of entries in the page table |
| mem_req | output | 1 | Table read request, held until `mem_ack` |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_ack | input | 1 | One-cycle read response strobe |
| mem_rdata | input | 32 | Table entry returned with `mem_ack` |
| flush_all | input | 1 | Invalidate every buffer entry |
| flush_sel | input | 1 | Invalidate the entries of one identifier |
| flush_id | input | 8 | Identifier used by `flush_sel` |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 32 | Physical address, valid with `done` when `fault` is low |
| fault | output | 1 | Translation fault, valid with `done` |

## Verification
The assertions assume a requester that keeps `req_valid`, `req_va` and `req_asid` steady from acceptance until `done`. They also assume a memory that pulses `mem_ack` for one cycle, and only while `mem_req` is high. They further assume that `tbl_base`, `tbl_len` and the flush inputs change only while no request is in flight. The stimulus drives requests at falling edges, drops them right after seeing `done`, and pulses flushes only between requests. Its memory model answers one falling edge after it sees `mem_req` and clears the strobe on the next.

// File: rtl/pg_xlate_pkg.sv
package pg_xlate_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_DONE  = 2'd2
   } walk_state_e;
endpackage

// File: rtl/pg_tlb.sv
module pg_tlb #(
   parameter int VPN_W   = 20,
   parameter int FRAME_W = 20,
   parameter int ASID_W  = 8,
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [ASID_W-1:0]  lk_asid,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic [ENTRIES-1:0] lk_hit_vec,
   input  logic               fill_en,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               flush_all,
   input  logic               flush_sel,
   input  logic [ASID_W-1:0]  flush_id
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] ent_vld;
   logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
   logic [ASID_W-1:0]  ent_asid  [ENTRIES];
   logic [FRAME_W-1:0] ent_frame [ENTRIES];
   logic [IDX_W-1:0]   victim;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign lk_hit_vec[e] = ent_vld[e] && (ent_vpn[e] == lk_vpn) && (ent_asid[e] == lk_asid);
   end

   assign lk_hit = |lk_hit_vec;

   always_comb begin
      lk_frame = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (lk_hit_vec[e]) lk_frame = lk_frame | ent_frame[e];
      end
   end

   // flush takes priority over a fill in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= '0;
         victim  <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            ent_vpn[e]   <= '0;
            ent_asid[e]  <= '0;
            ent_frame[e] <= '0;
         end
      end else begin
         if (fill_en) begin
            ent_vld[victim]   <= 1'b1;
            ent_vpn[victim]   <= lk_vpn;
            ent_asid[victim]  <= lk_asid;
            ent_frame[victim] <= fill_frame;
            victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
         end
         if (flush_all) begin
            ent_vld <= '0;
         end else if (flush_sel) begin
            for (int e = 0; e < ENTRIES; e++) begin
               if (ent_asid[e] == flush_id) ent_vld[e] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/pg_walk.sv
module pg_walk
   import pg_xlate_pkg::*;
#(
   parameter int VPN_W    = 20,
   parameter int FRAME_W  = 20,
   parameter int PG_SHIFT = 12,
   parameter int ADDR_W   = 32,
   parameter int PTE_W    = 32,
   parameter int PTE_SH   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [VPN_W-1:0]             req_vpn,
   input  logic [PG_SHIFT-1:0]          req_off,
   input  logic                         tlb_hit,
   input  logic [FRAME_W-1:0]           tlb_frame,
   input  logic [ADDR_W-1:0]            tbl_base,
   input  logic [VPN_W:0]               tbl_len,
   output logic                         mem_req,
   output logic [ADDR_W-1:0]            mem_addr,
   input  logic                         mem_ack,
   input  logic [PTE_W-1:0]             mem_rdata,
   output logic                         fill_en,
   output logic [FRAME_W-1:0]           fill_frame,
   output logic                         walk_idle,
   output logic                         done,
   output logic                         fault,
   output logic [FRAME_W+PG_SHIFT-1:0]  pa
);
   localparam int PA_W = FRAME_W + PG_SHIFT;

   walk_state_e          st;
   logic [ADDR_W-1:0]    addr_q;
   logic [PA_W-1:0]      pa_q;
   logic                 fault_q;
   logic                 pte_ok;

   assign pte_ok     = mem_rdata[0];
   assign fill_frame = mem_rdata[PG_SHIFT +: FRAME_W];
   assign fill_en    = (st == WK_FETCH) && mem_ack && pte_ok;
   assign walk_idle  = (st == WK_IDLE);
   assign mem_req    = (st == WK_FETCH);
   assign mem_addr   = addr_q;
   assign done       = (st == WK_DONE);
   assign fault      = fault_q;
   assign pa         = pa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= WK_IDLE;
         addr_q  <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (st)
            WK_IDLE: if (req_valid) begin
               if (tlb_hit) begin
                  pa_q    <= {tlb_frame, req_off};
                  fault_q <= 1'b0;
                  st      <= WK_DONE;
               end else if ({1'b0, req_vpn} >= tbl_len) begin
                  pa_q    <= '0;
                  fault_q <= 1'b1;
                  st      <= WK_DONE;
               end else begin
                  addr_q  <= tbl_base + (ADDR_W'(req_vpn) << PTE_SH);
                  st      <= WK_FETCH;
               end
            end
            WK_FETCH: if (mem_ack) begin
               pa_q    <= pte_ok ? {fill_frame, req_off} : '0;
               fault_q <= !pte_ok;
               st      <= WK_DONE;
            end
            WK_DONE: st <= WK_IDLE;
            default: st <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pg_xlate.sv
module pg_xlate #(
   parameter int VA_W      = 32,
   parameter int PG_SHIFT  = 12,
   parameter int PTE_BYTES = 4,
   parameter int FRAME_W   = 20,
   parameter int ADDR_W    = 32,
   parameter int ASID_W    = 8,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PG_SHIFT,
   localparam int PTE_W    = 8 * PTE_BYTES,
   localparam int PA_W     = FRAME_W + PG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [VPN_W:0]    tbl_len,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [PTE_W-1:0]  mem_rdata,
   input  logic              flush_all,
   input  logic              flush_sel,
   input  logic [ASID_W-1:0] flush_id,
   output logic              done,
   output logic [PA_W-1:0]   pa,
   output logic              fault
);
   localparam int PTE_SH = $clog2(PTE_BYTES);

   if (PG_SHIFT < 1 || PG_SHIFT >= VA_W) begin : g_bad_shift
      $error("pg_xlate: PG_SHIFT must lie inside the virtual address");
   end
   if (PG_SHIFT + FRAME_W > PTE_W) begin : g_bad_pte
      $error("pg_xlate: frame field does not fit in a table entry");
   end
   if ((1 << PTE_SH) != PTE_BYTES) begin : g_bad_bytes
      $error("pg_xlate: PTE_BYTES must be a power of two");
   end
   if (ENTRIES < 1) begin : g_bad_depth
      $error("pg_xlate: ENTRIES must be at least 1");
   end

   logic [VPN_W-1:0]    req_vpn;
   logic [PG_SHIFT-1:0] req_off;
   logic                tlb_hit;
   logic [FRAME_W-1:0]  tlb_frame;
   logic [ENTRIES-1:0]  tlb_hit_vec;
   logic                fill_en;
   logic [FRAME_W-1:0]  fill_frame;
   logic                walk_idle;

   assign req_vpn = req_va[VA_W-1:PG_SHIFT];
   assign req_off = req_va[PG_SHIFT-1:0];

   pg_tlb #(
      .VPN_W(VPN_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)
   ) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(req_vpn), .lk_asid(req_asid),
      .lk_hit(tlb_hit), .lk_frame(tlb_frame), .lk_hit_vec(tlb_hit_vec),
      .fill_en(fill_en), .fill_frame(fill_frame),
      .flush_all(flush_all), .flush_sel(flush_sel), .flush_id(flush_id)
   );

   pg_walk #(
      .VPN_W(VPN_W), .FRAME_W(FRAME_W), .PG_SHIFT(PG_SHIFT),
      .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PTE_SH(PTE_SH)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
      .tlb_hit(tlb_hit), .tlb_frame(tlb_frame),
      .tbl_base(tbl_base), .tbl_len(tbl_len),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fill_en(fill_en), .fill_frame(fill_frame), .walk_idle(walk_idle),
      .done(done), .fault(fault), .pa(pa)
   );
endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk #(
   parameter int VPN_W   = 20,
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [VPN_W-1:0]   vpn,
   input logic [VPN_W:0]     tbl_len,
   input logic               walk_idle,
   input logic               tlb_hit,
   input logic [ENTRIES-1:0] hit_vec,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               done,
   input logic               fault
);
   // R1
   hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_idle && req_valid && tlb_hit |=> done && !fault && !mem_req);
   // R2
   ack_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> done && !mem_req);
   // R3
   bound_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_idle && req_valid && !tlb_hit && ({1'b0, vpn} >= tbl_len) |=> done && fault && !mem_req);
   // R6
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

bind pg_xlate pg_xlate_chk #(
   .VPN_W(VPN_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vpn(req_vpn),
   .tbl_len(tbl_len), .walk_idle(walk_idle), .tlb_hit(tlb_hit),
   .hit_vec(tlb_hit_vec), .mem_req(mem_req), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .done(done), .fault(fault)
);

// File: tb/pg_xlate_test.sv
module pg_xlate_test;
   localparam int CLK_P  = 10;
   localparam logic [31:0] BASE = 32'h0000_4000;
   localparam int LEN    = 200;
   localparam int BADPG  = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [7:0]  req_asid = '0;
   logic [31:0] tbl_base = BASE;
   logic [20:0] tbl_len = 21'(LEN);
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        flush_all = 1'b0;
   logic        flush_sel = 1'b0;
   logic [7:0]  flush_id = '0;
   logic        done;
   logic [31:0] pa;
   logic        fault;

   int checks = 0;
   int fails  = 0;
   int mem_cnt = 0;
   logic [31:0] last_addr = '0;

   typedef struct {
      bit          flt;
      logic [31:0] pa;
      int          walks;
      logic [31:0] addr;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   pg_xlate uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_asid(req_asid), .tbl_base(tbl_base), .tbl_len(tbl_len),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .flush_all(flush_all), .flush_sel(flush_sel),
      .flush_id(flush_id), .done(done), .pa(pa), .fault(fault)
   );

   function automatic logic [19:0] frame_of(input logic [19:0] vpn);
      return 20'(vpn * 7 + 20'h100);
   endfunction

   // table content: frame in 31:12, valid in bit 0
   function automatic logic [31:0] pte_of(input logic [31:0] addr);
      logic [19:0] vpn;
      vpn = 20'((addr - BASE) >> 2);
      return {frame_of(vpn), 11'd0, (vpn != 20'(BADPG))};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory model: answers one falling edge after seeing a request
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= pte_of(mem_addr);
         last_addr <= mem_addr;
         mem_cnt   <= mem_cnt + 1;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // monitor: pops the scoreboard on every completion
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (done) begin
            if (sb.size() == 0) begin
               check("R10 unexpected done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " fault"}, {31'd0, fault}, {31'd0, e.flt});
               if (!e.flt) check({e.tag, " pa"}, pa, e.pa);
               check({e.tag, " reads"}, mem_cnt, e.walks);
               if (e.walks > 0) check({e.tag, " addr"}, last_addr, e.addr);
               mem_cnt = 0;
            end
         end
      end
   end

   task automatic xlate(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [7:0] asid, input bit flt, input int walks,
                        input string tag);
      exp_t e;
      int n;
      e.flt   = flt;
      e.pa    = flt ? 32'd0 : {frame_of(vpn), off};
      e.walks = walks;
      e.addr  = BASE + {10'd0, vpn, 2'b00};
      e.tag   = tag;
      @(negedge clk);
      sb.push_back(e);
      req_valid = 1'b1;
      req_va    = {vpn, off};
      req_asid  = asid;
      n = 0;
      do begin
         @(posedge clk);
         #1;
         n++;
      end while (!done && n < 60);
      if (!done) check({tag, " watchdog"}, 32'd0, 32'd1);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      check({tag, " R10 one-cycle done"}, {31'd0, done}, 32'd0);
   endtask

   task automatic pulse_flush(input bit all, input logic [7:0] id);
      @(negedge clk);
      flush_all = all;
      flush_sel = !all;
      flush_id  = id;
      @(negedge clk);
      flush_all = 1'b0;
      flush_sel = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check("watchdog expired", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset done", {31'd0, done}, 32'd0);
      check("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      // R11: empty buffer, first request must walk
      xlate(20'd5, 12'h0AB, 8'd1, 1'b0, 1, "R11 R2 first miss");
      xlate(20'd5, 12'h123, 8'd1, 1'b0, 0, "R1 R6 hit after fill");
      xlate(20'd5, 12'h456, 8'd2, 1'b0, 1, "R5 other id walks");
      xlate(20'd5, 12'hFFF, 8'd2, 1'b0, 0, "R5 second id hits");
      // R3 bound: LEN-1 in range, LEN faults without a read
      xlate(20'(LEN), 12'h010, 8'd1, 1'b1, 0, "R3 at length");
      xlate(20'(LEN + 77), 12'h010, 8'd1, 1'b1, 0, "R3 beyond length");
      xlate(20'(LEN - 1), 12'h020, 8'd1, 1'b0, 1, "R2 last page");
      // R4 invalid entry faults and is not installed
      xlate(20'(BADPG), 12'h000, 8'd1, 1'b1, 1, "R4 invalid entry");
      xlate(20'(BADPG), 12'h000, 8'd1, 1'b1, 1, "R4 invalid repeat walks");
      // R8 flush everything
      pulse_flush(1'b1, 8'd0);
      xlate(20'd5, 12'h123, 8'd1, 1'b0, 1, "R8 walk after flush");
      pulse_flush(1'b1, 8'd0);
      // R7 round-robin eviction
      for (int i = 0; i < 8; i++) xlate(20'(10 + i), 12'h0, 8'd3, 1'b0, 1, "R7 fill");
      xlate(20'd10, 12'h7, 8'd3, 1'b0, 0, "R7 oldest still held");
      xlate(20'd18, 12'h8, 8'd3, 1'b0, 1, "R7 ninth fill");
      xlate(20'd11, 12'h9, 8'd3, 1'b0, 0, "R7 second survives");
      xlate(20'd10, 12'hA, 8'd3, 1'b0, 1, "R7 oldest evicted");
      // R9 flush by identifier
      pulse_flush(1'b1, 8'd0);
      xlate(20'd20, 12'h1, 8'd4, 1'b0, 1, "R9 fill id4");
      xlate(20'd21, 12'h2, 8'd5, 1'b0, 1, "R9 fill id5");
      pulse_flush(1'b0, 8'd4);
      xlate(20'd21, 12'h3, 8'd5, 1'b0, 0, "R9 id5 kept");
      xlate(20'd20, 12'h4, 8'd4, 1'b0, 1, "R9 id4 dropped");
      repeat (4) @(posedge clk);
      check("R10 scoreboard drained", sb.size(), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule